// File: doc/BRIEF.md
# Capture Stall Handshake Controller

This controller steers a trace-recording card through its operating modes. From rest (IDLE) the host can start a capture fed from the remote cable (ACQUIRE), a capture fed by its own 16-bit writes (HOSTWRITE), or go straight to reading the buffer out (EXTRACT). Mode changes are commands written to an I/O port. A second port address returns a status byte.

While either capture mode is active, the buffer modules write into their RAM. When any module raises its almost-full flag, the controller raises a stall request towards the system under test. An acknowledge to that request moves the card to EXTRACT. If any module reports full before the acknowledge arrives, the controller stops writing at once and moves to EXTRACT. Input that follows is dropped, so the result is a sampled trace rather than a complete one. The host ends extraction, or aborts a capture, with an idle command.

States and transitions: IDLE→ACQUIRE (acquire command), IDLE→HOSTWRITE (host-write command), IDLE→EXTRACT (extract command), ACQUIRE/HOSTWRITE→EXTRACT (full, or acknowledge while a stall is pending), ACQUIRE/HOSTWRITE→IDLE (idle command), EXTRACT→IDLE (idle command). The stall request is a flag held beside the state. It is set in a capture state on almost-full and cleared whenever the capture state is left.

Top module: `capstall_ctrl`

## Requirements
- R1: After reset the controller is in IDLE, with rec_en, ext_en, cable_oe, hostbus_oe and srq all low.
- R2: A write of code 1 to the command address (CMD_ADDR, default 0) in IDLE enters ACQUIRE on the next clock. In ACQUIRE, rec_en and cable_oe are high.
- R3: A write of code 2 to the command address in IDLE enters HOSTWRITE on the next clock. In HOSTWRITE, rec_en and hostbus_oe are high.
- R4: cable_oe and hostbus_oe are never high together.
- R5: In a capture state, if any almost-full bit is high (and no full bit, acknowledge or idle command ends the capture), srq is high from the next clock. It stays high until the capture state is left.
- R6: sack, sampled high while srq is high in a capture state, gives EXTRACT on the next clock. In EXTRACT, ext_en is high and rec_en and srq are low.
- R7: Any full bit high in a capture state gives EXTRACT on the next clock, whether or not an acknowledge has arrived. Full takes precedence over an acknowledge in the same cycle.
- R8: sack while no stall is pending has no effect.
- R9: Code 0 returns the controller to IDLE from EXTRACT or from a capture state. Codes 1 and 2 are ignored outside IDLE.
- R10: A read at the status address (STAT_ADDR, default 1) returns bits[1:0] = mode (0 IDLE, 1 ACQUIRE, 2 HOSTWRITE, 3 EXTRACT), bit2 = any almost-full, bit3 = any full, and zeros above. io_rdata is 0 when no status read is in progress.
- R11: Code 3 in IDLE enters EXTRACT on the next clock.
- R12: Writes to any address other than the command address leave the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Host I/O write strobe |
| io_rd | input | 1 | Host I/O read strobe |
| io_addr | input | ADDR_W | Host I/O port offset |
| io_wdata | input | 2 | Command code |
| io_rdata | output | 8 | Status byte |
| afull_i | input | NMOD | Almost-full flag per buffer module |
| full_i | input | NMOD | Full flag per buffer module |
| sack | input | 1 | Stall acknowledge from the system under test |
| srq | output | 1 | Stall request to the system under test |
| rec_en | output | 1 | Buffer modules write into RAM |
| ext_en | output | 1 | Buffer modules are read out to the host |
| cable_oe | output | 1 | Output enable of the cable data register |
| hostbus_oe | output | 1 | Output enable of the local bus transceiver |

## Verification
The end of a capture is tried in three ways, and each path gives a different EXTRACT entry:
- almost-full, then acknowledge;
- full alone, with no stall request ever raised;
- full and acknowledge together in the same cycle while a stall is pending.

An acknowledge with no stall pending, out-of-state commands and writes to a foreign address are mixed in. These show that only the intended triggers move the mode. Status reads are taken in three situations: no flags, almost-full only, and full plus almost-full. This separates the mode field from the two flag bits.

// File: rtl/capstall_pkg.sv
package capstall_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACQ     = 2'd1,
        ST_HOSTWR  = 2'd2,
        ST_EXTRACT = 2'd3
    } state_t;

    typedef enum logic [1:0] {
        CMD_IDLE    = 2'd0,
        CMD_ACQ     = 2'd1,
        CMD_HOSTWR  = 2'd2,
        CMD_EXTRACT = 2'd3
    } cmd_t;

    typedef struct packed {
        logic go_idle;
        logic go_acq;
        logic go_hostwr;
        logic go_extract;
    } cmd_pulse_t;

endpackage

// File: rtl/capstall_cmd_decode.sv
module capstall_cmd_decode
    import capstall_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int CMD_ADDR = 0
) (
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [1:0]        io_wdata,
    output cmd_pulse_t        cmd
);
    localparam logic [ADDR_W-1:0] CMD_OFS = ADDR_W'(CMD_ADDR);

    logic hit;
    assign hit = io_wr && (io_addr == CMD_OFS);

    always_comb begin
        cmd = '0;
        if (hit) begin
            unique case (cmd_t'(io_wdata))
                CMD_IDLE:    cmd.go_idle    = 1'b1;
                CMD_ACQ:     cmd.go_acq     = 1'b1;
                CMD_HOSTWR:  cmd.go_hostwr  = 1'b1;
                CMD_EXTRACT: cmd.go_extract = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/capstall_flag_merge.sv
module capstall_flag_merge #(
    parameter int NMOD = 4
) (
    input  logic [NMOD-1:0] afull_i,
    input  logic [NMOD-1:0] full_i,
    output logic            any_afull,
    output logic            any_full
);
    logic [NMOD:0] af_chain;
    logic [NMOD:0] f_chain;

    assign af_chain[0] = 1'b0;
    assign f_chain[0]  = 1'b0;

    for (genvar m = 0; m < NMOD; m++) begin : g_merge
        assign af_chain[m+1] = af_chain[m] | afull_i[m];
        assign f_chain[m+1]  = f_chain[m]  | full_i[m];
    end

    assign any_afull = af_chain[NMOD];
    assign any_full  = f_chain[NMOD];
endmodule

// File: rtl/capstall_mode_fsm.sv
module capstall_mode_fsm
    import capstall_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cmd_pulse_t cmd,
    input  logic       any_afull,
    input  logic       any_full,
    input  logic       sack,
    output state_t     st,
    output logic       srq,
    output logic       rec_en,
    output logic       ext_en,
    output logic       cable_oe,
    output logic       hostbus_oe
);
    state_t st_nxt;
    logic   srq_q, srq_nxt;
    logic   recording;

    assign recording = (st == ST_ACQ) || (st == ST_HOSTWR);

    always_comb begin
        st_nxt  = st;
        srq_nxt = srq_q;
        unique case (st)
            ST_IDLE: begin
                srq_nxt = 1'b0;
                if (cmd.go_acq)          st_nxt = ST_ACQ;
                else if (cmd.go_hostwr)  st_nxt = ST_HOSTWR;
                else if (cmd.go_extract) st_nxt = ST_EXTRACT;
            end
            ST_ACQ, ST_HOSTWR: begin
                if (any_full) begin
                    st_nxt  = ST_EXTRACT;
                    srq_nxt = 1'b0;
                end else if (srq_q && sack) begin
                    st_nxt  = ST_EXTRACT;
                    srq_nxt = 1'b0;
                end else if (cmd.go_idle) begin
                    st_nxt  = ST_IDLE;
                    srq_nxt = 1'b0;
                end else if (any_afull) begin
                    srq_nxt = 1'b1;
                end
            end
            ST_EXTRACT: begin
                srq_nxt = 1'b0;
                if (cmd.go_idle) st_nxt = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            srq_q <= 1'b0;
        end else begin
            st    <= st_nxt;
            srq_q <= srq_nxt;
        end
    end

    always_comb begin
        rec_en     = 1'b0;
        ext_en     = 1'b0;
        cable_oe   = 1'b0;
        hostbus_oe = 1'b0;
        unique case (st)
            ST_IDLE:    ;
            ST_ACQ:     begin rec_en = 1'b1; cable_oe   = 1'b1; end
            ST_HOSTWR:  begin rec_en = 1'b1; hostbus_oe = 1'b1; end
            ST_EXTRACT: ext_en = 1'b1;
        endcase
    end

    assign srq = srq_q;

    assert_oe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cable_oe && hostbus_oe));

    assert_full_extract_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (recording && any_full) |=> (st == ST_EXTRACT && !srq_q));

    assert_ack_extract_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (recording && srq_q && sack) |=> (st == ST_EXTRACT));

    assert_stall_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (recording && any_afull && !any_full && !srq_q && !cmd.go_idle) |=> srq_q);

    assert_no_srq_extract_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EXTRACT) |-> !srq_q);

    assert_extract_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EXTRACT && !cmd.go_idle) |=> (st == ST_EXTRACT));
endmodule

// File: rtl/capstall_ctrl.sv
module capstall_ctrl
    import capstall_pkg::*;
#(
    parameter int NMOD      = 4,
    parameter int ADDR_W    = 4,
    parameter int CMD_ADDR  = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [1:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [NMOD-1:0]   afull_i,
    input  logic [NMOD-1:0]   full_i,
    input  logic              sack,
    output logic              srq,
    output logic              rec_en,
    output logic              ext_en,
    output logic              cable_oe,
    output logic              hostbus_oe
);
    localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(STAT_ADDR);

    cmd_pulse_t cmd;
    logic       any_afull, any_full;
    state_t     st;

    capstall_cmd_decode #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) u_dec (
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .io_wdata(io_wdata),
        .cmd     (cmd)
    );

    capstall_flag_merge #(.NMOD(NMOD)) u_flags (
        .afull_i  (afull_i),
        .full_i   (full_i),
        .any_afull(any_afull),
        .any_full (any_full)
    );

    capstall_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .any_afull (any_afull),
        .any_full  (any_full),
        .sack      (sack),
        .st        (st),
        .srq       (srq),
        .rec_en    (rec_en),
        .ext_en    (ext_en),
        .cable_oe  (cable_oe),
        .hostbus_oe(hostbus_oe)
    );

    always_comb begin
        io_rdata = 8'h00;
        if (io_rd && io_addr == STAT_OFS)
            io_rdata = {4'b0000, any_full, any_afull, st};
    end
endmodule

// File: tb/sim_capstall_ctrl.sv
module sim_capstall_ctrl;
    localparam int NMOD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_wr = 1'b0, io_rd = 1'b0;
    logic [3:0] io_addr = '0;
    logic [1:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic [NMOD-1:0] afull_i = '0, full_i = '0;
    logic       sack = 1'b0;
    logic       srq, rec_en, ext_en, cable_oe, hostbus_oe;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    typedef struct {
        string      req;
        logic [4:0] outs;
        logic [7:0] rd;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    capstall_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .afull_i(afull_i), .full_i(full_i), .sack(sack), .srq(srq),
        .rec_en(rec_en), .ext_en(ext_en), .cable_oe(cable_oe),
        .hostbus_oe(hostbus_oe)
    );

    // outs = {rec_en, ext_en, cable_oe, hostbus_oe, srq}
    task automatic step(input string req, input logic wr, input logic [3:0] a,
                        input logic [1:0] d, input logic rd, input logic [3:0] af,
                        input logic [3:0] f, input logic ak,
                        input logic [4:0] e_outs, input logic [7:0] e_rd);
        exp_t e;
        @(negedge clk);
        io_wr = wr; io_addr = a; io_wdata = d; io_rd = rd;
        afull_i = af; full_i = f; sack = ak;
        e.req = req; e.outs = e_outs; e.rd = e_rd;
        q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_cmp++;
                if ({rec_en, ext_en, cable_oe, hostbus_oe, srq} !== e.outs ||
                    io_rdata !== e.rd) begin
                    n_bad++;
                    $display("FAIL %s: outs=%b rdata=%h expected outs=%b rdata=%h",
                             e.req, {rec_en, ext_en, cable_oe, hostbus_oe, srq},
                             io_rdata, e.outs, e.rd);
                end
            end
        end
    end

    initial begin : watchdog
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #2;
        n_cmp++;
        if ({rec_en, ext_en, cable_oe, hostbus_oe, srq} !== 5'b00000) begin
            n_bad++;
            $display("FAIL R1: outs=%b expected 00000 in reset",
                     {rec_en, ext_en, cable_oe, hostbus_oe, srq});
        end
        @(negedge clk); rst_n = 1'b1;
        // R1 idle after reset, status mode 0
        step("R1",  0, 4'd1, 2'd0, 1, 4'h0, 4'h0, 0, 5'b00000, 8'h00);
        // R2 acquire
        step("R2",  1, 4'd0, 2'd1, 0, 4'h0, 4'h0, 0, 5'b10100, 8'h00);
        step("R10", 0, 4'd1, 2'd0, 1, 4'h0, 4'h0, 0, 5'b10100, 8'h01);
        // R8 stray acknowledge
        step("R8",  0, 4'd0, 2'd0, 0, 4'h0, 4'h0, 1, 5'b10100, 8'h00);
        // R9 host-write code ignored in ACQUIRE
        step("R9",  1, 4'd0, 2'd2, 0, 4'h0, 4'h0, 0, 5'b10100, 8'h00);
        // R5 almost-full raises stall request
        step("R5",  0, 4'd1, 2'd0, 1, 4'h4, 4'h0, 0, 5'b10101, 8'h05);
        step("R5",  0, 4'd0, 2'd0, 0, 4'h4, 4'h0, 0, 5'b10101, 8'h00);
        // R6 acknowledge moves to extract
        step("R6",  0, 4'd0, 2'd0, 0, 4'h4, 4'h0, 1, 5'b01000, 8'h00);
        step("R9",  1, 4'd0, 2'd0, 0, 4'h0, 4'h0, 0, 5'b00000, 8'h00);
        // R3 host-write
        step("R3",  1, 4'd0, 2'd2, 0, 4'h0, 4'h0, 0, 5'b10010, 8'h00);
        // R12 foreign address
        step("R12", 1, 4'd2, 2'd0, 0, 4'h0, 4'h0, 0, 5'b10010, 8'h00);
        // R7 full without acknowledge
        step("R7",  0, 4'd1, 2'd0, 1, 4'h2, 4'h1, 0, 5'b01000, 8'h0F);
        step("R9",  1, 4'd0, 2'd1, 0, 4'h0, 4'h0, 0, 5'b01000, 8'h00);
        step("R9",  1, 4'd0, 2'd0, 0, 4'h0, 4'h0, 0, 5'b00000, 8'h00);
        // R11 direct extract
        step("R11", 1, 4'd0, 2'd3, 0, 4'h0, 4'h0, 0, 5'b01000, 8'h00);
        step("R9",  1, 4'd0, 2'd0, 0, 4'h0, 4'h0, 0, 5'b00000, 8'h00);
        // R7 full and acknowledge together while stall pending
        step("R2",  1, 4'd0, 2'd1, 0, 4'h0, 4'h0, 0, 5'b10100, 8'h00);
        step("R5",  0, 4'd0, 2'd0, 0, 4'h1, 4'h0, 0, 5'b10101, 8'h00);
        step("R7",  0, 4'd0, 2'd0, 0, 4'h1, 4'h8, 1, 5'b01000, 8'h00);
        step("R9",  1, 4'd0, 2'd0, 0, 4'h0, 4'h0, 0, 5'b00000, 8'h00);
        // R9 abort a capture
        step("R2",  1, 4'd0, 2'd1, 0, 4'h0, 4'h0, 0, 5'b10100, 8'h00);
        step("R9",  1, 4'd0, 2'd0, 0, 4'h0, 4'h0, 0, 5'b00000, 8'h00);
        @(negedge clk);
        io_wr = 0; io_rd = 0; sack = 0; afull_i = '0; full_i = '0;
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule